// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time-of-Day Counter

This block keeps a free-running 64-bit count of whole nanoseconds for a precision-time hardware clock. Under the nanosecond count sits a 32-bit fractional accumulator. On every clock cycle in which counting is enabled, a programmable increment is added to the combined value. The increment has 32 integer bits and 32 fractional bits. Because of the fractional part, the clock can run at a non-integer number of nanoseconds per tick, for example 1.6 ns or 3.2 ns. The current count leaves the block on a dedicated output, where timestamp capture logic can pick it up.

Software reaches the block through a 32-bit register port. Two rules keep split-word accesses coherent:
- Reading the time low word freezes the matching upper half into a shadow, and a later high-word read returns that shadow.
- A write to a low word (time or increment) is only staged. The high-word write commits the staged low word and the new high word together as one 64-bit update.

Top module: `tod_clock`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the nanosecond count, the fraction, the active increment, the enable bit and the read data.
- R2: The register addresses are:
  - 0: control, where bit 0 is the count enable.
  - 1: time low word.
  - 2: time high word.
  - 3: increment low word.
  - 4: increment high word.
  The read data is registered and appears after the clock edge that takes the read strobe. A control read returns the enable in bit 0 and zero in all other bits.
- R3: In a cycle where the enable was already set, {nanoseconds, fraction} grows by the active increment. The increment has 32 integer bits and 32 fractional bits, and the fraction's carry goes into the nanoseconds. While the enable is clear, the count holds.
- R4: A time low-word read returns the low 32 bits of the count and captures the upper 32 bits into a shadow. A time high-word read returns that shadow, even if the count has moved on since.
- R5: A time low-word write is only staged and does not change the count. The staged value survives any number of ticks until a time high-word write uses it.
- R6: A time high-word write loads {written word, staged low word} into the nanoseconds and clears the fraction. The load overrides the tick of that same cycle.
- R7: An increment low-word write is only staged. An increment high-word write makes {written word, staged low word} active, and the tick in that cycle still uses the old increment. Increment reads return the active increment.
- R8: An active increment of zero keeps the count from advancing, even while enabled.
- R9: The time output always shows the current nanosecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | 64 | Current nanosecond count |

## Verification
- Fractional truncation: ten ticks of 3.2 ns must add 31 ns, not 32, and the eleventh tick must add 4. A design that rounds, or that drops the fraction, gives a different count.
- Load clears the fraction: a load after a run leaves a residue in the fraction. If that residue is not cleared, the count after the load is off by one.
- Low-word staging:
  - A time high-word read after the low half has wrapped must return the frozen upper half. A design without the shadow returns the newer upper half.
  - A staged time or increment low word must show no effect while ticks run. A design that applies it early shows a jump or a rate change before the commit.
- Stop conditions: a zero increment and a cleared enable must each freeze the count exactly.

// File: rtl/tod_pkg.sv
// Package: address map shared by the register decode and the read port.
package tod_pkg;
    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_TLO  = 3'd1,
        ADDR_THI  = 3'd2,
        ADDR_ILO  = 3'd3,
        ADDR_IHI  = 3'd4
    } tod_addr_e;
endpackage

// File: rtl/tod_regif.sv
// Register write decode.
// Holds the enable bit and the active increment, and stages the low words.
// A high-word write produces a load (time) or a commit (increment).
// Assumes at most one write per cycle.
module tod_regif
    import tod_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [2:0]         addr,
    input  logic [REG_W-1:0]   wdata,
    output logic               en,
    output logic [2*REG_W-1:0] inc,
    output logic               load_en,
    output logic [2*REG_W-1:0] load_val
);
    logic [REG_W-1:0] stage_tlo;
    logic [REG_W-1:0] stage_ilo;

    // A time load fires on the high-word write and joins it with the staged low word.
    always_comb begin
        load_en  = wr && (addr == ADDR_THI);
        load_val = {wdata, stage_tlo};
    end

    // Control bit, staged low words and increment commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= 1'b0;
            inc       <= '0;
            stage_tlo <= '0;
            stage_ilo <= '0;
        end else if (wr) begin
            case (addr)
                ADDR_CTRL: en        <= wdata[0];
                ADDR_TLO:  stage_tlo <= wdata;
                ADDR_ILO:  stage_ilo <= wdata;
                ADDR_IHI:  inc       <= {wdata, stage_ilo};
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tod_accum.sv
// Time accumulator: {nanoseconds, fraction}.
// A load takes priority over the tick of the same cycle and clears the fraction.
// The increment has REG_W integer bits and REG_W fractional bits.
module tod_accum #(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2*REG_W-1:0] inc,
    input  logic               load_en,
    input  logic [2*REG_W-1:0] load_val,
    output logic [2*REG_W-1:0] time_ns
);
    localparam int NS_W   = 2 * REG_W;
    localparam int FRAC_W = REG_W;
    localparam int ACC_W  = NS_W + FRAC_W;
    localparam int PAD_W  = ACC_W - 2 * REG_W;

    logic [ACC_W-1:0] acc;

    // Load, or advance by the increment while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (load_en) begin
            acc <= {load_val, {FRAC_W{1'b0}}};
        end else if (en) begin
            acc <= acc + {{PAD_W{1'b0}}, inc};
        end
    end

    // The visible count is the integer part only.
    assign time_ns = acc[ACC_W-1:FRAC_W];
endmodule

// File: rtl/tod_readport.sv
// Registered read port.
// A time low-word read freezes the upper half into a shadow, and a high-word read returns it.
// Unmapped addresses read as zero.
module tod_readport
    import tod_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [2:0]         addr,
    input  logic               en,
    input  logic [2*REG_W-1:0] inc,
    input  logic [2*REG_W-1:0] time_ns,
    output logic [REG_W-1:0]   rdata
);
    logic [REG_W-1:0] shadow_hi;

    // Select the addressed word and update the shadow on low-word reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            shadow_hi <= '0;
        end else if (rd) begin
            case (addr)
                ADDR_CTRL: rdata <= {{(REG_W-1){1'b0}}, en};
                ADDR_TLO: begin
                    rdata     <= time_ns[REG_W-1:0];
                    shadow_hi <= time_ns[2*REG_W-1:REG_W];
                end
                ADDR_THI:  rdata <= shadow_hi;
                ADDR_ILO:  rdata <= inc[REG_W-1:0];
                ADDR_IHI:  rdata <= inc[2*REG_W-1:REG_W];
                default:   rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tod_clock.sv
// Top level: nanosecond time-of-day counter with fractional increment.
// Register decode, accumulator and read port are instantiated here.
// time_ns feeds external capture logic directly.
module tod_clock #(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [2*REG_W-1:0] time_ns
);
    logic               en_w;
    logic [2*REG_W-1:0] inc_w;
    logic               load_w;
    logic [2*REG_W-1:0] load_val_w;

    tod_regif #(.REG_W(REG_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en       (en_w),
        .inc      (inc_w),
        .load_en  (load_w),
        .load_val (load_val_w)
    );

    tod_accum #(.REG_W(REG_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_w),
        .inc      (inc_w),
        .load_en  (load_w),
        .load_val (load_val_w),
        .time_ns  (time_ns)
    );

    tod_readport #(.REG_W(REG_W)) u_readport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .en      (en_w),
        .inc     (inc_w),
        .time_ns (time_ns),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/tod_clock_chk.sv
// Checker for tod_clock.
// Relates register traffic to the count and to the active increment over time.
module tod_clock_chk
    import tod_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [2:0]         reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [2*REG_W-1:0] time_ns,
    input logic               en,
    input logic [2*REG_W-1:0] inc
);
    logic is_load;
    assign is_load = reg_wr && (reg_addr == ADDR_THI);

    // R3: the count holds while the enable is clear and no load happens.
    p_hold_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !is_load) |=> $stable(time_ns));

    // R3: one tick never moves the count by more than the integer increment plus one.
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_load) |=> ((time_ns - $past(time_ns)) <= ({{REG_W{1'b0}}, $past(inc[2*REG_W-1:REG_W])} + 1)));

    // R8: with a zero increment the count does not move.
    p_zero_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((inc == '0) && !is_load) |=> $stable(time_ns));

    // R6: a time high-word write sets the upper half of the count.
    p_load_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (time_ns[2*REG_W-1:REG_W] == $past(reg_wdata)));

    // R4: a time low-word read returns the count as it was when the read was taken.
    p_lo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_TLO) |=> (reg_rdata == $past(time_ns[REG_W-1:0])));

    // R7: a staged increment low word leaves the active increment unchanged.
    p_inc_staged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_ILO) |=> $stable(inc));
endmodule

bind tod_clock tod_clock_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_ns   (time_ns),
    .en        (en_w),
    .inc       (inc_w)
);

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    tod_clock u_tod_clock (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .time_ns(time_ns)
    );

    always #10 clk = ~clk;

    // Expected count after n ticks of increment incv from t (fraction starting at zero)
    function automatic logic [63:0] adv(logic [63:0] t, int n, logic [63:0] incv);
        logic [127:0] p;
        p = 128'(n) * {64'd0, incv};
        return t + p[95:32];
    endfunction

    task automatic chk64(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One operation per posedge; returns at the following negedge
    task automatic op(logic w, logic r, logic [2:0] a, logic [31:0] d);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        op(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_reg(logic [2:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        op(1'b0, 1'b1, a, 32'd0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 3'd0, 32'd0);
    endtask

    // Monitor: pops the expected read data once the registered result is present
    always @(posedge clk) begin
        if (reg_rd) begin
            #1;
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R2: unexpected read, actual %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] t;
        logic [63:0] inc16, inc32, inc3p2;
        inc16  = 64'h0000_0001_9999_9999;
        inc32  = 64'h0000_0020_0000_0000;
        inc3p2 = 64'h0000_0003_3333_3333;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;

        // R1: reset state
        chk64("R1 time after reset", time_ns, 64'd0);
        rd_reg(3'd0, 32'd0, "R1 ctrl after reset");
        rd_reg(3'd1, 32'd0, "R1 time low after reset");
        rd_reg(3'd4, 32'd0, "R1 increment high after reset");

        // R7 / R5 / R6 / R3 with enable clear
        wr_reg(3'd3, 32'h9999_9999);
        wr_reg(3'd4, 32'h0000_0001);
        rd_reg(3'd3, 32'h9999_9999, "R7 increment low readback");
        wr_reg(3'd1, 32'h0000_0010);
        idle(4);
        chk64("R5 staged time low has no effect", time_ns, 64'd0);
        wr_reg(3'd2, 32'h0000_0001);
        chk64("R6 load joins staged low", time_ns, 64'h0000_0001_0000_0010);
        idle(5);
        chk64("R3 disabled count holds", time_ns, 64'h0000_0001_0000_0010);

        // R2 / R3: enable and run at 1.6 ns per tick
        wr_reg(3'd0, 32'h1);
        rd_reg(3'd0, 32'h1, "R2 ctrl enable readback");
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd2, 32'd0);
        idle(10);
        chk64("R3 ten ticks of 1.6 ns", time_ns, adv(64'd0, 10, inc16));
        idle(1);
        chk64("R3 eleven ticks of 1.6 ns", time_ns, adv(64'd0, 11, inc16));

        // R4: snapshot across a low-word wrap, 32 ns per tick
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'h20);
        wr_reg(3'd1, 32'hFFFF_FFF0);
        wr_reg(3'd2, 32'h5);
        rd_reg(3'd1, 32'hFFFF_FFF0, "R4 low read value");
        idle(2);
        rd_reg(3'd2, 32'h5, "R4 high read returns snapshot");
        chk64("R9 time output after wrap", time_ns, adv(64'h5_FFFF_FFF0, 4, inc32));

        // R7: staged increment, commit cycle uses old increment; R3 fraction truncation
        wr_reg(3'd1, 32'd0);
        wr_reg(3'd2, 32'd0);
        wr_reg(3'd3, 32'h3333_3333);
        idle(3);
        chk64("R7 staged increment low keeps old rate", time_ns, 64'd128);
        rd_reg(3'd3, 32'd0, "R7 increment read returns active value");
        wr_reg(3'd4, 32'h3);
        chk64("R7 commit tick uses old increment", time_ns, 64'd192);
        idle(10);
        chk64("R3 ten ticks of 3.2 ns truncate", time_ns, adv(64'd192, 10, inc3p2));
        idle(1);
        chk64("R3 fraction carry on eleventh tick", time_ns, adv(64'd192, 11, inc3p2));

        // R6: load clears the fraction
        wr_reg(3'd1, 32'd1000);
        wr_reg(3'd2, 32'd0);
        idle(10);
        chk64("R6 load clears fraction", time_ns, adv(64'd1000, 10, inc3p2));

        // R8: zero increment stops the clock
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'd0);
        t = time_ns;
        idle(6);
        chk64("R8 zero increment holds", time_ns, t);
        rd_reg(3'd1, t[31:0], "R8 low read after zero increment");

        // R3: clearing the enable with a nonzero increment
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd4, 32'h20);
        wr_reg(3'd0, 32'd0);
        t = time_ns;
        idle(5);
        chk64("R3 enable clear holds", time_ns, t);

        // R5: staged low word survives running ticks
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd1, 32'hABCD_0000);
        idle(7);
        wr_reg(3'd2, 32'h2);
        chk64("R5 staged low kept across ticks", time_ns, 64'h0000_0002_ABCD_0000);

        idle(2);
        finish_run();
    end
endmodule